// File: doc/BRIEF.md
# Dual-Window MFM Read Data Separator

This block turns a raw MFM read-pulse stream into NRZ data for a disk or diskette read channel. An external phase-locked loop supplies a one-cycle strobe at a fixed multiple of the half-cell rate. The block divides that strobe down to half-cell boundaries, and these mark out two alternating framing windows, A and B. Each bit cell is an A window followed by a B window. Two capture registers each take the pulses that land in their own window. The result is two candidate NRZ streams, one bit of each per cell.

In MFM, one window of each cell carries clock bits and the other carries data bits, and nothing in the pulse train says which is which. The block therefore searches both streams for the sync mark at once. The mark is the 16-half-cell pattern 0x4489, which is byte 0xA1 with one clock pulse missing. The first stream in which the mark completes is latched as the data stream. From the next cell on, its bits go to the deserializer port. A channel select sets the strobe divisor for either the fast fixed-disk rate or the slow diskette rate; the defaults are a 20:1 ratio, as between 5 Mbit/s and 250 kbit/s. The raw pulse input is asynchronous and passes through a synchroniser with rising-edge detection.

Top module: `rds_separator`

## Requirements
- R1: While and just after `rst` is high, `cell_stb`, `nrz_a`, `nrz_b`, `mark_found`, `stream_b_sel`, `data_stb` and `data_bit` are all 0.
- R2: With `read_gate` high, the first window after `read_gate` rises is window A, and the windows then alternate A, B, A, B. A cell ends when its B window ends. In the cycle after a cell ends, `cell_stb` is 1 for one cycle. In that cycle `nrz_a` is 1 exactly when a pulse rose within that cell's A window, and `nrz_b` is 1 exactly when a pulse rose within its B window.
- R3: A window lasts `DIV_FAST` `loop_ref` strobes when `chan_slow` is 0, and `DIV_SLOW` strobes when `chan_slow` is 1. A cell therefore spans twice that many strobes.
- R4: `raw_pulse` counts once per rising edge. A level that rises in one window and stays high into the next window sets only the first window's bit.
- R5: Take the half-cells in order A0, B0, A1, B1, and so on. If the 16 most recent half-cells, oldest first, equal 0x4489 (MSB first) and the newest of them is a B half, then at the end of that cell `mark_found` becomes 1 with `stream_b_sel` = 1. Both are visible in the `cell_stb` cycle.
- R6: If that match ends on an A half, it is detected at the end of the same cell, with `mark_found` = 1 and `stream_b_sel` = 0.
- R7: `data_stb` is 0 in the `cell_stb` cycle of the cell where the mark is found and in every cell before it. In each later cell it is 1, with `data_bit` equal to that cell's bit from the selected window (B if `stream_b_sel` is 1, otherwise A).
- R8: Once `mark_found` is 1, further sync patterns in either stream leave `mark_found` and `stream_b_sel` unchanged.
- R9: A one-cycle `resync` pulse clears `mark_found` and `stream_b_sel` and stops `data_stb`. The search restarts at the next cell end and may lock onto either stream. If `resync` falls in a cycle where a cell ends, the clear takes priority.
- R10: With `read_gate` low, `mark_found`, `data_stb` and the window phase are cleared, so the next rise of `read_gate` starts again in window A with no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_pulse | input | 1 | Asynchronous raw MFM read pulse |
| loop_ref | input | 1 | One-cycle strobe from the external loop |
| chan_slow | input | 1 | 0 = fixed-disk divisor, 1 = diskette divisor |
| read_gate | input | 1 | High while reading; low clears the block |
| resync | input | 1 | Drop the current lock and search again |
| nrz_a | output | 1 | Window A bit of the last cell |
| nrz_b | output | 1 | Window B bit of the last cell |
| cell_stb | output | 1 | One cycle after each cell ends |
| mark_found | output | 1 | Sync mark has been located |
| stream_b_sel | output | 1 | 1 = window B carries data |
| data_bit | output | 1 | Selected-stream data bit |
| data_stb | output | 1 | `data_bit` is valid this cycle |

## Verification
A wrong window phase or divisor count moves pulses into the wrong window. That shows up at the next `cell_stb` as swapped or missing `nrz_a`/`nrz_b` bits, or as a gap between strobes that is not twice the divisor. A corrupted mark history or lock register shows within one cell of the mark: `mark_found` rises at the wrong cell, or `stream_b_sel` points at the clock window, and then every later `data_bit` follows the wrong window. A lock that failed to hold, or failed to clear on resync or gate drop, is caught at the first `cell_stb` after the event.

// File: rtl/rds_pkg.sv
package rds_pkg;

  typedef enum logic {WIN_A = 1'b0, WIN_B = 1'b1} win_t;

  localparam logic [15:0] DEFAULT_MARK = 16'h4489;

  // bit 1: match ending on the A half (hist[16:1]); bit 0: ending on B (hist[15:0])
  function automatic logic [1:0] mark_hits(input logic [16:0] hist, input logic [15:0] mark);
    logic [1:0] h;
    h[1] = (hist[16:1] == mark);
    h[0] = (hist[15:0] == mark);
    return h;
  endfunction

endpackage

// File: rtl/rds_pulse_sync.sv
module rds_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], raw};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // a held level yields a single detected edge
  assert_single_edge_R4: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/rds_window_gen.sv
module rds_window_gen #(
  parameter int DIV_FAST = 1,
  parameter int DIV_SLOW = 20,
  parameter int CNT_W    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          loop_ref,
  input  logic          chan_slow,
  output rds_pkg::win_t phase,
  output logic          cell_end
);
  import rds_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             half_end;

  always_comb begin
    term     = chan_slow ? CNT_W'(DIV_SLOW - 1) : CNT_W'(DIV_FAST - 1);
    half_end = run && loop_ref && (cnt_q >= term);
    cell_end = half_end && (phase == WIN_B);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      phase <= WIN_A;
    end else if (loop_ref) begin
      if (cnt_q >= term) begin
        cnt_q <= '0;
        phase <= (phase == WIN_A) ? WIN_B : WIN_A;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // a cell always closes out of window B and reopens in window A
  assert_cell_restarts_a_R2: assert property (@(posedge clk) disable iff (rst)
    cell_end |=> (phase == WIN_A));

  assert_gate_low_phase_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase == WIN_A));

endmodule

// File: rtl/rds_capture.sv
module rds_capture #(
  parameter int WIN_IDX = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          pulse,
  input  rds_pkg::win_t phase,
  input  logic          cell_end,
  output logic          bit_next,
  output logic          bit_hold
);
  localparam logic WBIT = WIN_IDX[0];

  logic cap_q;
  logic in_win;

  always_comb begin
    in_win   = pulse && (logic'(phase) == WBIT);
    bit_next = cap_q | in_win;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cap_q    <= 1'b0;
      bit_hold <= 1'b0;
    end else if (cell_end) begin
      bit_hold <= bit_next;
      cap_q    <= 1'b0;
    end else if (in_win) begin
      cap_q <= 1'b1;
    end
  end

  // second rank changes only at a cell boundary
  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !cell_end) |=> $stable(bit_hold));

endmodule

// File: rtl/rds_mark_detect.sv
module rds_mark_detect #(
  parameter logic [15:0] MARK = rds_pkg::DEFAULT_MARK
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic resync,
  input  logic cell_end,
  input  logic a_next,
  input  logic b_next,
  output logic found,
  output logic sel_b,
  output logic data_bit,
  output logic data_stb
);
  import rds_pkg::*;

  logic [16:0] hist_q;
  logic [16:0] hist_n;
  logic [1:0]  hits;

  always_comb begin
    hist_n = {hist_q[14:0], a_next, b_next};
    hits   = mark_hits(hist_n, MARK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q   <= '0;
      found    <= 1'b0;
      sel_b    <= 1'b0;
      data_bit <= 1'b0;
      data_stb <= 1'b0;
    end else begin
      data_stb <= 1'b0;
      if (!run) begin
        hist_q   <= '0;
        found    <= 1'b0;
        sel_b    <= 1'b0;
        data_bit <= 1'b0;
      end else begin
        if (cell_end) hist_q <= hist_n;
        if (resync) begin
          found <= 1'b0;
          sel_b <= 1'b0;
        end else if (cell_end) begin
          if (found) begin
            data_stb <= 1'b1;
            data_bit <= sel_b ? b_next : a_next;
          end else if (hits != 2'b00) begin
            found <= 1'b1;
            sel_b <= !hits[1];
          end
        end
      end
    end
  end

  assert_data_after_lock_R7: assert property (@(posedge clk) disable iff (rst)
    data_stb |-> found);

  assert_lock_latched_R8: assert property (@(posedge clk) disable iff (rst)
    (found && run && !resync) |=> (found && $stable(sel_b)));

  assert_lock_at_cell_end_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> $past(cell_end));

  assert_resync_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (run && resync) |=> (!found && !data_stb));

  assert_gate_clears_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!found && !data_stb));

endmodule

// File: rtl/rds_separator.sv
module rds_separator #(
  parameter int          SYNC_STAGES = 2,
  parameter int          DIV_FAST    = 1,
  parameter int          DIV_SLOW    = 20,
  parameter logic [15:0] MARK        = rds_pkg::DEFAULT_MARK
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_pulse,
  input  logic loop_ref,
  input  logic chan_slow,
  input  logic read_gate,
  input  logic resync,
  output logic nrz_a,
  output logic nrz_b,
  output logic cell_stb,
  output logic mark_found,
  output logic stream_b_sel,
  output logic data_bit,
  output logic data_stb
);
  import rds_pkg::*;

  localparam int DIV_MAX  = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int CNT_W    = (DIV_MAX < 2) ? 1 : $clog2(DIV_MAX);
  localparam int N_WIN    = 2;

  logic       pulse;
  win_t       phase;
  logic       cell_end;
  logic [N_WIN-1:0] bit_next;
  logic [N_WIN-1:0] bit_hold;

  rds_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .raw  (raw_pulse),
    .rise (pulse)
  );

  rds_window_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .CNT_W(CNT_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .run       (read_gate),
    .loop_ref  (loop_ref),
    .chan_slow (chan_slow),
    .phase     (phase),
    .cell_end  (cell_end)
  );

  for (genvar w = 0; w < N_WIN; w++) begin : g_cap
    rds_capture #(.WIN_IDX(w)) u_cap (
      .clk      (clk),
      .rst      (rst),
      .run      (read_gate),
      .pulse    (pulse),
      .phase    (phase),
      .cell_end (cell_end),
      .bit_next (bit_next[w]),
      .bit_hold (bit_hold[w])
    );
  end

  rds_mark_detect #(.MARK(MARK)) u_mark (
    .clk      (clk),
    .rst      (rst),
    .run      (read_gate),
    .resync   (resync),
    .cell_end (cell_end),
    .a_next   (bit_next[0]),
    .b_next   (bit_next[1]),
    .found    (mark_found),
    .sel_b    (stream_b_sel),
    .data_bit (data_bit),
    .data_stb (data_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) cell_stb <= 1'b0;
    else     cell_stb <= cell_end;
  end

  assign nrz_a = bit_hold[0];
  assign nrz_b = bit_hold[1];

  // data is only ever offered alongside a cell strobe
  assert_data_with_cell_R7: assert property (@(posedge clk) disable iff (rst)
    data_stb |-> cell_stb);

endmodule

// File: tb/rds_separator_tb.sv
module rds_separator_tb;

  localparam int DIVF = 1;
  localparam int DIVS = 20;
  localparam logic [15:0] MK = 16'h4489;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_pulse = 1'b0, loop_ref = 1'b0, chan_slow = 1'b0, read_gate = 1'b0, resync = 1'b0;
  logic nrz_a, nrz_b, cell_stb, mark_found, stream_b_sel, data_bit, data_stb;

  always #5 clk = ~clk;

  rds_separator #(.SYNC_STAGES(2), .DIV_FAST(DIVF), .DIV_SLOW(DIVS), .MARK(MK)) u_dut (
    .clk(clk), .rst(rst), .raw_pulse(raw_pulse), .loop_ref(loop_ref), .chan_slow(chan_slow),
    .read_gate(read_gate), .resync(resync), .nrz_a(nrz_a), .nrz_b(nrz_b), .cell_stb(cell_stb),
    .mark_found(mark_found), .stream_b_sel(stream_b_sel), .data_bit(data_bit), .data_stb(data_stb)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  bit hv [0:255];
  bit hs [0:255];
  int nh;

  bit r_a [0:127];
  bit r_b [0:127];
  bit r_f [0:127];
  bit r_s [0:127];
  bit r_d [0:127];
  bit r_v [0:127];
  int r_c [0:127];
  int rc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cell_stb && rc < 128) begin
      r_a[rc] = nrz_a; r_b[rc] = nrz_b; r_f[rc] = mark_found; r_s[rc] = stream_b_sel;
      r_d[rc] = data_bit; r_v[rc] = data_stb; r_c[rc] = cyc;
      rc = rc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit hb(input int i);
    return (i >= 0 && i < nh) ? hv[i] : 1'b0;
  endfunction

  function automatic bit mark_end(input int e);
    for (int j = 0; j < 16; j++)
      if (hb(e - 15 + j) != MK[15 - j]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic clear_seq(); nh = 0; endtask
  task automatic add_half(input bit v, input bit s); hv[nh] = v; hs[nh] = s; nh++; endtask
  task automatic add_rand(input int n);
    for (int i = 0; i < n; i++) add_half(($urandom % 3) == 0, 1'b0);
  endtask
  task automatic add_mark();
    for (int j = 0; j < 16; j++) add_half(MK[15 - j], 1'b0);
  endtask

  task automatic run_seq(input string name, input bit slow, input int rs_cell);
    int p, dv, ncell;
    bit ef, es;
    p  = slow ? 2 : 8;
    dv = slow ? DIVS : DIVF;
    // gate low clears any previous lock (R10)
    @(negedge clk); read_gate = 1'b0; loop_ref = 1'b0; raw_pulse = 1'b0; resync = 1'b0;
    chan_slow = slow;
    repeat (3) @(negedge clk);
    chk(mark_found == 1'b0 && data_stb == 1'b0, "R10", int'(mark_found), 0, {name, " gate low clears lock"});
    rc = 0;
    for (int i = 0; i < nh; i++) begin
      for (int d = 0; d < dv; d++) begin
        for (int c = 0; c < p; c++) begin
          if (!(i == 0 && d == 0 && c == 0)) @(negedge clk);
          read_gate = 1'b1;
          loop_ref  = (c == p - 1);
          resync    = (rs_cell >= 0 && i == 2 * rs_cell && d == 0 && c == 0);
          if (hv[i]) raw_pulse = (d == 0) ? (c >= 1 && (hs[i] || c <= 2)) : hs[i];
          else       raw_pulse = (i > 0 && hs[i-1] && d == 0 && c == 0);
        end
      end
    end
    @(negedge clk); loop_ref = 1'b0; raw_pulse = 1'b0; resync = 1'b0;
    repeat (4) @(negedge clk);
    ncell = nh / 2;
    chk(rc == ncell, "R2", rc, ncell, {name, " cell strobe count"});
    if (rc >= 2)
      chk(r_c[1] - r_c[0] == 2 * dv * p, "R3", r_c[1] - r_c[0], 2 * dv * p, {name, " cycles per cell"});
    if (rc >= 1)
      chk(r_a[0] == hb(0), "R10", int'(r_a[0]), int'(hb(0)), {name, " first window after gate is A"});
    ef = 1'b0; es = 1'b0;
    for (int k = 0; k < ncell && k < rc; k++) begin
      bit ev, eb;
      ev = 1'b0; eb = 1'b0;
      if (k == rs_cell) begin ef = 1'b0; es = 1'b0; end
      if (ef) begin ev = 1'b1; eb = es ? hb(2*k+1) : hb(2*k); end
      else if (mark_end(2*k))   begin ef = 1'b1; es = 1'b0; end
      else if (mark_end(2*k+1)) begin ef = 1'b1; es = 1'b1; end
      chk(r_a[k] == hb(2*k) && r_b[k] == hb(2*k+1), "R2",
          {r_a[k], r_b[k]}, {hb(2*k), hb(2*k+1)}, $sformatf("%s cell %0d nrz a/b", name, k));
      chk(r_f[k] == ef && (!ef || r_s[k] == es), es ? "R5" : "R6",
          {r_f[k], r_s[k]}, {ef, es}, $sformatf("%s cell %0d lock/select", name, k));
      chk(r_v[k] == ev && (!ev || r_d[k] == eb), "R7",
          {r_v[k], r_d[k]}, {ev, eb}, $sformatf("%s cell %0d data", name, k));
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(cell_stb == 0 && nrz_a == 0 && nrz_b == 0 && mark_found == 0 && stream_b_sel == 0
        && data_stb == 0 && data_bit == 0, "R1", int'(mark_found), 0, "outputs during reset");
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(cell_stb == 0 && mark_found == 0 && data_stb == 0, "R1", int'(cell_stb), 0, "outputs after reset");

    // R5: mark ends on a B half
    clear_seq(); add_rand(10); add_mark(); add_rand(20);
    run_seq("fastB", 1'b0, -1);
    // R6: mark ends on an A half
    clear_seq(); add_rand(9); add_mark(); add_rand(21);
    run_seq("fastA", 1'b0, -1);
    // R3: slow channel
    clear_seq(); add_rand(4); add_mark(); add_rand(12);
    run_seq("slowB", 1'b1, -1);
    // R8: a second mark in the other window is ignored
    clear_seq(); add_rand(2); add_mark(); add_rand(3); add_mark(); add_rand(7);
    run_seq("latch", 1'b0, -1);
    chk(stream_b_sel == 1'b1 && mark_found == 1'b1, "R8", int'(stream_b_sel), 1, "selection kept after second mark");
    // R9: resync drops lock, relocks on A window
    clear_seq(); add_rand(2); add_mark(); add_rand(9); add_mark(); add_rand(9);
    run_seq("resync", 1'b0, 14);
    chk(stream_b_sel == 1'b0 && mark_found == 1'b1, "R9", int'(stream_b_sel), 0, "relocked on other stream");
    // R4: level held from window A into window B counts once
    clear_seq(); add_half(1'b1, 1'b1); add_half(1'b0, 1'b0); add_half(1'b0, 1'b0); add_half(1'b1, 1'b1);
    add_half(1'b0, 1'b0); add_half(1'b0, 1'b0); add_rand(6);
    run_seq("longpulse", 1'b0, -1);
    chk(r_b[0] == 1'b0 && r_a[0] == 1'b1, "R4", {r_a[0], r_b[0]}, 2, "held level in A only");
    chk(r_a[2] == 1'b0, "R4", int'(r_a[2]), 0, "held level from B does not reach next A");

    // randomised runs on both channels
    for (int t = 0; t < 8; t++) begin
      int pre;
      bit sl;
      pre = $urandom % 21;
      sl  = $urandom % 2;
      clear_seq(); add_rand(pre); add_mark(); add_rand(16 + (pre % 2));
      run_seq($sformatf("rand%0d", t), sl, -1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule